// File: doc/BRIEF.md
# Serial Scan Chain Refresh Controller

This block runs a daisy chain of identical scan cells, each carrying 8 bits, from the fast system clock. In one refresh it writes a byte into the input latch of one chosen cell and reads back that cell's output byte. Software or board logic picks the target with an index and supplies the byte. The controller makes the scan clock, the serial data, the select line and the latch strobe. It assembles the returned byte from the serial stream that comes out of the far end of the chain.

Each refresh has a fixed order. First a write phase runs with select low, and the byte travels down the chain to the target. Then the latch strobe copies chain contents into the cell inputs. Next a capture clock runs with select high, and after it a read phase brings the target's captured output to the far end. Idle gaps of programmable length separate the phases so that slow chain wiring meets hold time. Refreshes run back to back without stopping. A single-cycle `ready` pulse marks the end of each one, and the new result appears on `out_data` in the same cycle. The gap length comes from a default parameter. It can be overridden from pins, but only while reset is held.

Top module: `scan_chain_driver`

## Requirements
- R1: While `rst_n` is low (synchronous reset), `scan_clk`, `scan_dout`, `scan_sel`, `scan_latch` and `ready` are 0 and `out_data` is 0.
- R2: Write phase: with `scan_sel` low, the controller gives 8×(k+1) scan clocks for target k. The first eight bits on `scan_dout` are the sampled byte, most significant bit first, and later bits are 0. Cell k then latches exactly that byte.
- R3: Each scan clock pulse is high for exactly one system cycle and low for at least one, so shifting runs at half the system rate. `scan_dout` and `scan_sel` do not change while `scan_clk` is high.
- R4: Each refresh has exactly one `scan_latch` pulse, one cycle wide. It comes W+1 cycles after the last write clock, where W is the wait count, with `scan_clk` and `scan_sel` low.
- R5: Capture: after a further W+1 idle cycles, `scan_sel` rises and exactly one scan clock is given. Select then stays high for W+1 cycles before it drops.
- R6: Read phase: with `scan_sel` low, the controller gives 8×(N−k) scan clocks, where N is the chain length. `scan_din` is sampled in the low half of each of the last eight clocks, first sample = bit 7. The result equals cell k's output byte.
- R7: `ready` is high for exactly one cycle per refresh. `out_data` takes the new byte in that same cycle and holds it until the next pulse.
- R8: Refreshes repeat continuously. Each lasts 16×(N+1)+3×W+8 system cycles and has 8×N+9 scan clocks.
- R9: The index and data byte are sampled once, in the cycle after `ready` (or the first cycle after reset). Changes later in a refresh take effect in the next one.
- R10: An index of N or more is treated as N−1, the last cell.
- R11: W is loaded during reset. It takes `wait_cfg` when `cfg_sel` is 2'b11 and `DEFAULT_WAIT` otherwise. Outside reset, `cfg_sel` and `wait_cfg` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active_idx | input | IDX_W | Index of the target cell (0 = nearest to the driver) |
| data_in | input | DATA_W | Byte to write into the target cell |
| cfg_sel | input | 2 | Wait override enable, honoured only in reset when 2'b11 |
| wait_cfg | input | WAIT_W | Wait count to load when override is enabled |
| scan_din | input | 1 | Serial data returning from the far end of the chain |
| scan_clk | output | 1 | Scan clock to the chain |
| scan_dout | output | 1 | Serial data into the chain |
| scan_sel | output | 1 | High: cells capture design outputs; low: cells shift |
| scan_latch | output | 1 | Strobe copying chain contents into the cell input latches |
| out_data | output | DATA_W | Byte read back from the target cell |
| ready | output | 1 | One-cycle pulse at the end of each refresh |

## Verification
Two things are hard to reach from the ports. One is a wait count other than the default, because it can only be loaded while reset is asserted. The other is a byte or index change in the middle of a refresh. The bench drives reset several times with different override settings and with changing settings outside reset. It measures the refresh length in each case. A behavioural model of the chain, with a per-cell output function that depends on position, confirms that the right cell was written and that its byte came back. Indices past the chain end and inputs changed halfway through a refresh are part of the sweep.

// File: rtl/scan_drv_pkg.sv
`timescale 1ns/1ps
package scan_drv_pkg;

  typedef enum logic [3:0] {
    ST_LOAD,
    ST_SHIFT,
    ST_WAIT_A,
    ST_LATCH,
    ST_WAIT_B,
    ST_CAPT,
    ST_WAIT_C,
    ST_READ,
    ST_DONE
  } drv_state_e;

  // Index past the end of the chain falls back to the last cell.
  function automatic int unsigned clamp_index(input int unsigned idx, input int unsigned n);
    return (idx >= n) ? (n - 1) : idx;
  endfunction

  // Scan clocks needed to push the byte into cell idx.
  function automatic int unsigned write_clocks(input int unsigned idx, input int unsigned w);
    return w * (idx + 1);
  endfunction

  // Scan clocks needed after capture to bring cell idx out of the chain end.
  function automatic int unsigned read_clocks(input int unsigned idx, input int unsigned n,
                                              input int unsigned w);
    return w * (n - idx);
  endfunction

endpackage

// File: rtl/scan_drv_waitcfg.sv
`timescale 1ns/1ps
module scan_drv_waitcfg #(
  parameter int WAIT_W       = 8,
  parameter int DEFAULT_WAIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_sel,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic [WAIT_W-1:0] wait_val
);

  localparam logic [WAIT_W-1:0] DEF_VAL = WAIT_W'(DEFAULT_WAIT);

  logic [WAIT_W-1:0] wait_q;

  // Loaded on every reset cycle; frozen once reset is released.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= (cfg_sel == 2'b11) ? wait_cfg : DEF_VAL;
    end
  end

  assign wait_val = wait_q;

endmodule

// File: rtl/scan_drv_ser.sv
`timescale 1ns/1ps
module scan_drv_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              ser_bit
);

  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= load_val;
    end else if (shift) begin
      sr_q <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  assign ser_bit = sr_q[DATA_W-1];

endmodule

// File: rtl/scan_drv_deser.sv
`timescale 1ns/1ps
module scan_drv_deser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              bit_in,
  input  logic              commit,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (take) begin
      rx_q <= {rx_q[DATA_W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (commit) begin
      word_q <= rx_q;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/scan_drv_seq.sv
`timescale 1ns/1ps
module scan_drv_seq
  import scan_drv_pkg::*;
#(
  parameter int NUM_DESIGNS = 250,
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 9,
  parameter int WAIT_W      = 8,
  parameter int CNT_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  active_idx,
  input  logic [WAIT_W-1:0] wait_val,
  output logic              load,
  output logic              shift_adv,
  output logic              rx_take,
  output logic              rx_commit,
  output logic              drive_en,
  output logic              scan_clk,
  output logic              scan_sel,
  output logic              scan_latch,
  output logic              ready
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] RX_SPAN  = CNT_W'(DATA_W);

  drv_state_e       state;
  logic             ph;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] sel_idx;
  logic [CNT_W-1:0] wait_ld;
  logic             last_clk;

  assign sel_idx  = IDX_W'(clamp_index(32'(active_idx), NUM_DESIGNS));
  assign wait_ld  = CNT_W'(wait_val);
  assign last_clk = ph && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_LOAD;
      ph    <= 1'b0;
      cnt   <= '0;
      idx_q <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          idx_q <= sel_idx;
          cnt   <= CNT_W'(write_clocks(32'(sel_idx), DATA_W));
          ph    <= 1'b0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          ph <= ~ph;
          if (last_clk) begin
            cnt   <= wait_ld;
            state <= ST_WAIT_A;
          end else if (ph) begin
            cnt <= cnt - ONE;
          end
        end
        ST_WAIT_A: begin
          if (cnt == '0) state <= ST_LATCH;
          else           cnt   <= cnt - ONE;
        end
        ST_LATCH: begin
          cnt   <= wait_ld;
          state <= ST_WAIT_B;
        end
        ST_WAIT_B: begin
          if (cnt == '0) begin
            ph    <= 1'b0;
            state <= ST_CAPT;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_CAPT: begin
          ph <= ~ph;
          if (ph) begin
            cnt   <= wait_ld;
            state <= ST_WAIT_C;
          end
        end
        ST_WAIT_C: begin
          if (cnt == '0) begin
            cnt   <= CNT_W'(read_clocks(32'(idx_q), NUM_DESIGNS, DATA_W));
            ph    <= 1'b0;
            state <= ST_READ;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_READ: begin
          ph <= ~ph;
          if (last_clk)  state <= ST_DONE;
          else if (ph)   cnt   <= cnt - ONE;
        end
        ST_DONE: begin
          state <= ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  // Named events brought out for the datapath and for the checker.
  assign load       = (state == ST_LOAD);
  assign drive_en   = (state == ST_SHIFT);
  assign shift_adv  = (state == ST_SHIFT) && ph;
  assign rx_take    = (state == ST_READ) && !ph && (cnt <= RX_SPAN);
  assign rx_commit  = (state == ST_READ) && last_clk;
  assign scan_clk   = ph;
  assign scan_sel   = (state == ST_CAPT) || (state == ST_WAIT_C);
  assign scan_latch = (state == ST_LATCH);
  assign ready      = (state == ST_DONE);

endmodule

// File: rtl/scan_chain_driver.sv
`timescale 1ns/1ps
module scan_chain_driver #(
  parameter int NUM_DESIGNS  = 250,
  parameter int DATA_W       = 8,
  parameter int IDX_W        = 9,
  parameter int WAIT_W       = 8,
  parameter int DEFAULT_WAIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  active_idx,
  input  logic [DATA_W-1:0] data_in,
  input  logic [1:0]        cfg_sel,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              scan_din,
  output logic              scan_clk,
  output logic              scan_dout,
  output logic              scan_sel,
  output logic              scan_latch,
  output logic [DATA_W-1:0] out_data,
  output logic              ready
);

  localparam int CHAIN_BITS = DATA_W * NUM_DESIGNS;
  localparam int CLK_W      = $clog2(CHAIN_BITS + 1);
  localparam int CNT_W      = (CLK_W > WAIT_W) ? CLK_W : WAIT_W;

  logic [WAIT_W-1:0] wait_val;
  logic              load;
  logic              shift_adv;
  logic              rx_take;
  logic              rx_commit;
  logic              drive_en;
  logic              ser_bit;

  scan_drv_waitcfg #(
    .WAIT_W      (WAIT_W),
    .DEFAULT_WAIT(DEFAULT_WAIT)
  ) u_waitcfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_sel (cfg_sel),
    .wait_cfg(wait_cfg),
    .wait_val(wait_val)
  );

  scan_drv_seq #(
    .NUM_DESIGNS(NUM_DESIGNS),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .WAIT_W     (WAIT_W),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_idx(active_idx),
    .wait_val  (wait_val),
    .load      (load),
    .shift_adv (shift_adv),
    .rx_take   (rx_take),
    .rx_commit (rx_commit),
    .drive_en  (drive_en),
    .scan_clk  (scan_clk),
    .scan_sel  (scan_sel),
    .scan_latch(scan_latch),
    .ready     (ready)
  );

  scan_drv_ser #(.DATA_W(DATA_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(data_in),
    .shift   (shift_adv),
    .ser_bit (ser_bit)
  );

  scan_drv_deser #(.DATA_W(DATA_W)) u_deser (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (rx_take),
    .bit_in(scan_din),
    .commit(rx_commit),
    .word  (out_data)
  );

  assign scan_dout = drive_en & ser_bit;

endmodule

// File: rtl/scan_chain_driver_chk.sv
`timescale 1ns/1ps
module scan_chain_driver_chk #(
  parameter int DATA_W = 8,
  parameter int WAIT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_clk,
  input logic              scan_dout,
  input logic              scan_sel,
  input logic              scan_latch,
  input logic              ready,
  input logic              rx_take,
  input logic [DATA_W-1:0] out_data,
  input logic [WAIT_W-1:0] wait_val
);

  assert_clk_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_clk |=> !scan_clk);

  assert_hold_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_clk |-> ($stable(scan_dout) && $stable(scan_sel)));

  assert_latch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_latch |-> (!scan_clk && !scan_sel));

  assert_latch_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_latch |=> !scan_latch);

  assert_rx_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |-> (!scan_clk && !scan_sel));

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!scan_clk && !scan_sel && !scan_latch));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $stable(out_data));

  assert_wait_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(wait_val));

endmodule

bind scan_chain_driver scan_chain_driver_chk #(
  .DATA_W(DATA_W),
  .WAIT_W(WAIT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scan_clk  (scan_clk),
  .scan_dout (scan_dout),
  .scan_sel  (scan_sel),
  .scan_latch(scan_latch),
  .ready     (ready),
  .rx_take   (rx_take),
  .out_data  (out_data),
  .wait_val  (wait_val)
);

// File: tb/scan_chain_driver_bench.sv
`timescale 1ns/1ps
module scan_chain_driver_bench;

  localparam int N    = 4;
  localparam int DW   = 8;
  localparam int IW   = 9;
  localparam int WW   = 6;
  localparam int DEFW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [IW-1:0] active_idx;
  logic [DW-1:0] data_in;
  logic [1:0]    cfg_sel;
  logic [WW-1:0] wait_cfg;
  logic          scan_din;
  logic          scan_clk, scan_dout, scan_sel, scan_latch, ready;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  scan_chain_driver #(
    .NUM_DESIGNS(N), .DATA_W(DW), .IDX_W(IW), .WAIT_W(WW), .DEFAULT_WAIT(DEFW)
  ) u_scan_chain_driver (
    .clk(clk), .rst_n(rst_n), .active_idx(active_idx), .data_in(data_in),
    .cfg_sel(cfg_sel), .wait_cfg(wait_cfg), .scan_din(scan_din),
    .scan_clk(scan_clk), .scan_dout(scan_dout), .scan_sel(scan_sel),
    .scan_latch(scan_latch), .out_data(out_data), .ready(ready)
  );

  // ---------------- chain model ----------------
  function automatic logic [7:0] dut_fn(input int k, input logic [7:0] v);
    return ~v ^ 8'(k * 33);
  endfunction

  logic [8*N-1:0] chain = '0;
  logic [7:0]     cell_in [N];

  initial for (int k = 0; k < N; k++) cell_in[k] = 8'h00;

  always @(posedge scan_clk) begin
    if (scan_sel) begin
      for (int k = 0; k < N; k++) chain[8*k +: 8] <= dut_fn(k, cell_in[k]);
    end else begin
      chain <= {chain[8*N-2:0], scan_dout};
    end
  end

  always @(posedge scan_latch) begin
    for (int k = 0; k < N; k++) cell_in[k] <= chain[8*k +: 8];
  end

  assign scan_din = chain[8*N-1];

  // ---------------- bookkeeping ----------------
  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  int   cyc, last_rdy, rises, wr_clks, cap_clks, rd_clks, latches;
  int   pulse_bad = 0;
  logic [7:0] wbyte;
  bit   seen_latch, prev_clk, prev_rdy;
  int   s_period, s_rises, s_wr, s_cap, s_rd, s_latch;
  logic [7:0] s_wbyte;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; last_rdy = 0; rises = 0; wr_clks = 0; cap_clks = 0;
      rd_clks = 0; latches = 0; seen_latch = 0; wbyte = 8'h00;
    end else begin
      cyc++;
      if (scan_clk && !prev_clk) begin
        rises++;
        if (scan_sel) cap_clks++;
        else if (!seen_latch) begin
          if (wr_clks < 8) wbyte = {wbyte[6:0], scan_dout};
          else if (scan_dout) pulse_bad++;   // filler must be zero (R2)
          wr_clks++;
        end else rd_clks++;
      end
      if (scan_latch) begin
        latches++;
        seen_latch = 1;
      end
      if (ready && prev_rdy) pulse_bad++;
      if (ready) begin
        s_period = cyc - last_rdy; last_rdy = cyc;
        s_rises = rises; s_wr = wr_clks; s_cap = cap_clks; s_rd = rd_clks;
        s_latch = latches; s_wbyte = wbyte;
        rises = 0; wr_clks = 0; cap_clks = 0; rd_clks = 0; latches = 0;
        seen_latch = 0; wbyte = 8'h00;
      end
    end
    prev_clk = scan_clk;
    prev_rdy = ready;
  end

  // ---------------- tasks ----------------
  task automatic do_reset(input logic [1:0] sel, input logic [WW-1:0] w);
    @(negedge clk);
    rst_n = 1'b0; cfg_sel = sel; wait_cfg = w;
    repeat (4) @(negedge clk);
    check(!scan_clk && !scan_dout && !scan_sel && !scan_latch, "R1", "scan lines in reset",
          int'({scan_clk, scan_dout, scan_sel, scan_latch}), 0);
    check(!ready, "R1", "ready in reset", int'(ready), 0);
    check(out_data == 8'h00, "R1", "out_data in reset", int'(out_data), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_ready();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ready && n < 3000);
    #1;
    if (!ready) check(1'b0, "R7", "ready timeout", 0, 1);
  endtask

  function automatic int period_of(input int w);
    return 16 * (N + 1) + 3 * w + 8;
  endfunction

  task automatic check_refresh(input int idx, input logic [7:0] d, input int w);
    int ci;
    ci = (idx >= N) ? N - 1 : idx;
    check(out_data == dut_fn(ci, d), "R6", "read-back byte", int'(out_data), int'(dut_fn(ci, d)));
    check(s_wbyte == d, "R2", "first eight bits MSB first", int'(s_wbyte), int'(d));
    check(s_wr == 8 * (ci + 1), "R2", "write clocks", s_wr, 8 * (ci + 1));
    check(cell_in[ci] == d, "R2", "target cell latched byte", int'(cell_in[ci]), int'(d));
    check(s_latch == 1, "R4", "latch pulses", s_latch, 1);
    check(s_cap == 1, "R5", "capture clocks", s_cap, 1);
    check(s_rd == 8 * (N - ci), "R6", "read clocks", s_rd, 8 * (N - ci));
    check(s_rises == 8 * N + 9, "R8", "scan clocks per refresh", s_rises, 8 * N + 9);
    check(s_period == period_of(w), "R8", "refresh length", s_period, period_of(w));
  endtask

  // ---------------- stimulus ----------------
  logic [7:0] pats [7] = '{8'h00, 8'hFF, 8'h02, 8'hA5, 8'h5A, 8'h80, 8'h01};

  initial begin
    logic [7:0] prev;
    rst_n = 1'b0; cfg_sel = 2'b00; wait_cfg = '0; active_idx = '0; data_in = '0;
    do_reset(2'b00, 6'd0);
    wait_ready();
    prev = dut_fn(0, 8'h00);

    // Sweep every index (one past the end too) over several byte patterns.
    for (int idx = 0; idx <= N; idx++) begin
      for (int p = 0; p < 7; p++) begin
        active_idx = IW'(idx);
        data_in    = pats[p];
        repeat (20) @(negedge clk);
        check(out_data == prev, "R7", "out_data held mid-refresh", int'(out_data), int'(prev));
        wait_ready();
        check_refresh(idx, pats[p], DEFW);
        if (idx >= N)
          check(out_data == dut_fn(N - 1, pats[p]), "R10", "index past end clamps",
                int'(out_data), int'(dut_fn(N - 1, pats[p])));
        prev = dut_fn((idx >= N) ? N - 1 : idx, pats[p]);
      end
    end

    // R10: far out-of-range index.
    active_idx = 9'd511; data_in = 8'h96;
    wait_ready();
    check(out_data == dut_fn(N - 1, 8'h96), "R10", "index 511 clamps",
          int'(out_data), int'(dut_fn(N - 1, 8'h96)));

    // R9: inputs changed mid-refresh apply only to the next refresh.
    active_idx = 9'd1; data_in = 8'h3C;
    repeat (30) @(negedge clk);
    active_idx = 9'd2; data_in = 8'hC3;
    wait_ready();
    check(out_data == dut_fn(1, 8'h3C), "R9", "sampled at refresh start",
          int'(out_data), int'(dut_fn(1, 8'h3C)));
    wait_ready();
    check(out_data == dut_fn(2, 8'hC3), "R9", "new inputs next refresh",
          int'(out_data), int'(dut_fn(2, 8'hC3)));

    check(pulse_bad == 0, "R7", "ready single cycle and zero filler", pulse_bad, 0);

    // R11: override honoured in reset.
    active_idx = 9'd0; data_in = 8'h55;
    do_reset(2'b11, 6'd10);
    wait_ready();
    wait_ready();
    check_refresh(0, 8'h55, 10);
    check(s_period == period_of(10), "R11", "override wait length", s_period, period_of(10));

    // R11: cfg inputs ignored outside reset.
    cfg_sel = 2'b11; wait_cfg = 6'd1;
    wait_ready();
    wait_ready();
    check(s_period == period_of(10), "R11", "cfg ignored after reset", s_period, period_of(10));

    // R11: override not enabled -> default.
    active_idx = 9'd3; data_in = 8'hE7;
    do_reset(2'b01, 6'd10);
    wait_ready();
    wait_ready();
    check_refresh(3, 8'hE7, DEFW);
    check(s_period == period_of(DEFW), "R11", "default wait length", s_period, period_of(DEFW));

    check(pulse_bad == 0, "R7", "ready single cycle at end", pulse_bad, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired: actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule